// File: doc/BRIEF.md
# Indirect Firmware Loader with CPU Release

This block sits between a 16-bit host register bus and an embedded CPU's instruction memory. The host first puts the CPU control field into the load code, which holds the CPU in reset. It then sets a base word address and arms the loader by setting the top two bits of the indirect command register. After that it streams the firmware image through a single data port. Each write to the port becomes one word write on the memory port, and the target address moves up by one after every word.

Once the image is in place, the host writes the 32-bit start vector as two 16-bit halves and changes the control field to the start code. One cycle later the block raises `cpuRun`. At that same cycle it presents the start vector it latched at release on `cpuResetVec`. A status register tells the host whether the loader is ready, has already taken words, or is in a state where port writes would be refused.

Top module: `fw_boot_loader`

## Requirements
- R1: After reset, `cpuRun` and `memWrEn` are 0 and `cpuResetVec` is 0. The control and command registers and both vector halves read 0. The base register (offset 0x100) reads 0x1000. The status register (offset 0x103) reads 2.
- R2: The control register sits at offset 0x0E and reads back all 16 bits as written. Only bits 4:0 select the mode: 0x17 is load and 0x01 is start. Bits 15:5 never change the mode.
- R3: The indirect command register sits at offset 0x101 and reads back all 16 bits as written. The loader is armed exactly when bits 15:14 are both 1.
- R4: The status register reads 2 whenever the mode is not load or the loader is not armed. When loading is possible, it reads 0 if no word has been accepted since the last write to the control or command register, and 1 once a word has been accepted.
- R5: When the loader is in load mode and armed, a write to the data port (offset 0x102) produces `memWrEn`=1 on the next cycle. `memWrData` carries the written word, whose bits 7:0 hold the earlier image byte. `memWrAddr` carries the current target address, and that address then advances by one.
- R6: A write to offset 0x100 stores the base and makes it the target address of the next accepted port word. The base reads back unchanged while words are streamed.
- R7: A port write made while the mode is not load, or while the loader is not armed, leaves `memWrEn` at 0 and leaves the target address unchanged.
- R8: The start vector low half is at offset 0x3 and the high half at offset 0x4. Both read back as written.
- R9: `cpuRun` goes to 1 one cycle after the control field takes the start code, not in the same cycle. At that point `cpuResetVec` equals {high half, low half} as they stood at release. It holds that value while `cpuRun` stays 1, even if the halves are rewritten.
- R10: `cpuRun` returns to 0 one cycle after the control field leaves the start code. Any code other than 0x01 leaves the CPU not running.
- R11: A read of an unmapped offset, or of the data port, returns 0. `regRdData` is 0 whenever `regRd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regAddr | input | 16 | Register offset |
| regWrData | input | 16 | Register write data |
| regWr | input | 1 | Write strobe, one cycle per write |
| regRd | input | 1 | Read strobe |
| regRdData | output | 16 | Read data, valid in the same cycle as regRd |
| memWrEn | output | 1 | Instruction memory write enable |
| memWrAddr | output | 16 | Instruction memory word address |
| memWrData | output | 16 | Instruction memory write word |
| cpuRun | output | 1 | CPU released from reset |
| cpuResetVec | output | 32 | Start vector presented with cpuRun |

## Verification
The bench sweeps all 32 mode codes with junk in the upper control bits, with the loader armed. A design that decoded the whole register would never report load or start, and a design that matched too loosely would accept port words or release the CPU under the wrong codes. The bench then streams a byte-computed image, rebases it and re-arms it. An address counter that skipped a step, reused the base register or kept moving on refused words would put words at the wrong addresses. The release is sampled both in the write cycle and in the cycle after it, which catches a `cpuRun` that comes one cycle early. Vector halves are rewritten while the CPU is running, which exposes a vector that follows the live registers instead of the value latched at release.

// File: rtl/fwb_pkg.sv
package fwb_pkg;
  localparam int REG_W  = 16;
  localparam int MODE_W = 5;

  localparam logic [REG_W-1:0] OFS_VEC_LO = 16'h0003;
  localparam logic [REG_W-1:0] OFS_VEC_HI = 16'h0004;
  localparam logic [REG_W-1:0] OFS_CTRL   = 16'h000E;
  localparam logic [REG_W-1:0] OFS_BASE   = 16'h0100;
  localparam logic [REG_W-1:0] OFS_CMD    = 16'h0101;
  localparam logic [REG_W-1:0] OFS_PORT   = 16'h0102;
  localparam logic [REG_W-1:0] OFS_STAT   = 16'h0103;

  localparam logic [MODE_W-1:0] MODE_LOAD  = 5'h17;
  localparam logic [MODE_W-1:0] MODE_START = 5'h01;

  typedef enum logic [1:0] {
    ST_READY = 2'd0,
    ST_BUSY  = 2'd1,
    ST_FAULT = 2'd2
  } loadStatus_t;

  // strobes from control to datapath
  typedef struct packed {
    logic setBase;
    logic pushWord;
    logic setVecLo;
    logic setVecHi;
    logic latchVec;
  } dpStrobe_t;
endpackage

// File: rtl/fwb_ctrl.sv
module fwb_ctrl
  import fwb_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [DW-1:0] regAddr,
  input  logic [DW-1:0] regWrData,
  input  logic          regWr,
  input  logic          regRd,
  input  logic [DW-1:0] loadBase,
  input  logic [DW-1:0] vecLo,
  input  logic [DW-1:0] vecHi,
  output logic [DW-1:0] regRdData,
  output dpStrobe_t     strobe,
  output loadStatus_t   statusCode,
  output logic          cpuRun
);
  localparam int ST_W = $bits(loadStatus_t);

  logic [DW-1:0] ctrlReg;
  logic [DW-1:0] cmdReg;
  logic          wordSeen;
  logic          modeLoad;
  logic          modeStart;
  logic          armed;

  assign modeLoad  = (ctrlReg[MODE_W-1:0] == MODE_LOAD);
  assign modeStart = (ctrlReg[MODE_W-1:0] == MODE_START);
  assign armed     = &cmdReg[DW-1:DW-2];

  always_comb begin
    strobe          = '0;
    strobe.setBase  = regWr && (regAddr == OFS_BASE);
    strobe.pushWord = regWr && (regAddr == OFS_PORT) && modeLoad && armed;
    strobe.setVecLo = regWr && (regAddr == OFS_VEC_LO);
    strobe.setVecHi = regWr && (regAddr == OFS_VEC_HI);
    strobe.latchVec = modeStart && !cpuRun;
  end

  always_comb begin
    if (!(modeLoad && armed)) statusCode = ST_FAULT;
    else if (wordSeen)        statusCode = ST_BUSY;
    else                      statusCode = ST_READY;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg  <= '0;
      cmdReg   <= '0;
      wordSeen <= 1'b0;
      cpuRun   <= 1'b0;
    end else begin
      cpuRun <= modeStart;
      if (regWr && regAddr == OFS_CTRL) begin
        ctrlReg  <= regWrData;
        wordSeen <= 1'b0;
      end else if (regWr && regAddr == OFS_CMD) begin
        cmdReg   <= regWrData;
        wordSeen <= 1'b0;
      end else if (strobe.pushWord) begin
        wordSeen <= 1'b1;
      end
    end
  end

  always_comb begin
    regRdData = '0;
    if (regRd) begin
      case (regAddr)
        OFS_CTRL:   regRdData = ctrlReg;
        OFS_CMD:    regRdData = cmdReg;
        OFS_STAT:   regRdData = {{(DW-ST_W){1'b0}}, statusCode};
        OFS_BASE:   regRdData = loadBase;
        OFS_VEC_LO: regRdData = vecLo;
        OFS_VEC_HI: regRdData = vecHi;
        default:    regRdData = '0;
      endcase
    end
  end

  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.setBase, strobe.pushWord, strobe.setVecLo, strobe.setVecHi})) else $error("strobes overlap"); // R6
  AST_RUN_AFTER_START: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuRun) |-> $past(ctrlReg[MODE_W-1:0] == MODE_START)) else $error("run without start"); // R9
  AST_STOP_AFTER_LEAVE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cpuRun) |-> $past(ctrlReg[MODE_W-1:0] != MODE_START)) else $error("stop while start"); // R10
endmodule

// File: rtl/fwb_datapath.sv
module fwb_datapath
  import fwb_pkg::*;
#(
  parameter int          DW       = 16,
  parameter int          AW       = 16,
  parameter logic [15:0] BASE_RST = 16'h1000
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [DW-1:0]   regWrData,
  input  dpStrobe_t       strobe,
  input  logic            cpuRun,
  output logic [DW-1:0]   loadBase,
  output logic [DW-1:0]   vecLo,
  output logic [DW-1:0]   vecHi,
  output logic            memWrEn,
  output logic [AW-1:0]   memWrAddr,
  output logic [DW-1:0]   memWrData,
  output logic [2*DW-1:0] cpuResetVec
);
  localparam int VW = 2 * DW;

  logic [AW-1:0] curAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      loadBase    <= DW'(BASE_RST);
      curAddr     <= AW'(BASE_RST);
      vecLo       <= '0;
      vecHi       <= '0;
      memWrEn     <= 1'b0;
      memWrAddr   <= '0;
      memWrData   <= '0;
      cpuResetVec <= '0;
    end else begin
      memWrEn <= strobe.pushWord;
      if (strobe.setBase) begin
        loadBase <= regWrData;
        curAddr  <= regWrData[AW-1:0];
      end
      if (strobe.pushWord) begin
        memWrAddr <= curAddr;
        memWrData <= regWrData;
        curAddr   <= curAddr + 1'b1;
      end
      if (strobe.setVecLo) vecLo <= regWrData;
      if (strobe.setVecHi) vecHi <= regWrData;
      if (strobe.latchVec) cpuResetVec <= {vecHi, vecLo};
    end
  end

  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn && $past(memWrEn) |-> memWrAddr == $past(memWrAddr) + 1'b1) else $error("address skip"); // R5
  AST_VEC_HELD: assert property (@(posedge clk) disable iff (!rstN)
    cpuRun && $past(cpuRun) |-> $stable(cpuResetVec)) else $error("vector moved"); // R9
  AST_VEC_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cpuRun) |-> cpuResetVec == VW'($past({vecHi, vecLo}))) else $error("vector mismatch"); // R9
endmodule

// File: rtl/fw_boot_loader.sv
module fw_boot_loader
  import fwb_pkg::*;
#(
  parameter int          DW       = 16,
  parameter int          AW       = 16,
  parameter logic [15:0] BASE_RST = 16'h1000
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic [DW-1:0]   regAddr,
  input  logic [DW-1:0]   regWrData,
  input  logic            regWr,
  input  logic            regRd,
  output logic [DW-1:0]   regRdData,
  output logic            memWrEn,
  output logic [AW-1:0]   memWrAddr,
  output logic [DW-1:0]   memWrData,
  output logic            cpuRun,
  output logic [2*DW-1:0] cpuResetVec
);
  dpStrobe_t   strobe;
  loadStatus_t statusCode;
  logic [DW-1:0] loadBase;
  logic [DW-1:0] vecLo;
  logic [DW-1:0] vecHi;

  fwb_ctrl #(.DW(DW)) uCtrl (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrData(regWrData),
    .regWr(regWr), .regRd(regRd), .loadBase(loadBase), .vecLo(vecLo),
    .vecHi(vecHi), .regRdData(regRdData), .strobe(strobe),
    .statusCode(statusCode), .cpuRun(cpuRun)
  );

  fwb_datapath #(.DW(DW), .AW(AW), .BASE_RST(BASE_RST)) uData (
    .clk(clk), .rstN(rstN), .regWrData(regWrData), .strobe(strobe),
    .cpuRun(cpuRun), .loadBase(loadBase), .vecLo(vecLo), .vecHi(vecHi),
    .memWrEn(memWrEn), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .cpuResetVec(cpuResetVec)
  );

  AST_NO_WRITE_WHILE_RUN: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> !cpuRun) else $error("write while running"); // R10
  AST_WRITE_WHEN_READY: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> $past(statusCode != ST_FAULT)) else $error("write while faulted"); // R7
endmodule

// File: tb/sim_fw_boot_loader.sv
module sim_fw_boot_loader;
  localparam int CLK_PERIOD = 10;
  localparam int NWORDS = 16;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] regAddr = '0;
  logic [15:0] regWrData = '0;
  logic        regWr = 1'b0;
  logic        regRd = 1'b0;
  logic [15:0] regRdData;
  logic        memWrEn;
  logic [15:0] memWrAddr;
  logic [15:0] memWrData;
  logic        cpuRun;
  logic [31:0] cpuResetVec;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fw_boot_loader u0 (
    .clk(clk), .rstN(rstN), .regAddr(regAddr), .regWrData(regWrData),
    .regWr(regWr), .regRd(regRd), .regRdData(regRdData), .memWrEn(memWrEn),
    .memWrAddr(memWrAddr), .memWrData(memWrData), .cpuRun(cpuRun),
    .cpuResetVec(cpuResetVec)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [15:0] a, input logic [15:0] d);
    @(negedge clk);
    regAddr = a; regWrData = d; regWr = 1'b1;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rdReg(input logic [15:0] a, output logic [15:0] d);
    regAddr = a; regRd = 1'b1;
    #1 d = regRdData;
    regRd = 1'b0;
  endtask

  task automatic finishRun();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    finishRun();
  end

  initial begin
    logic [15:0] rd;
    logic [7:0]  img [2*NWORDS];
    for (int i = 0; i < 2*NWORDS; i++) img[i] = 8'(i*7 + 3);

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 cpuRun", 32'(cpuRun), 0);
    check("R1 memWrEn", 32'(memWrEn), 0);
    check("R1 vector", cpuResetVec, 0);
    rdReg(16'h000E, rd); check("R1 ctrl", 32'(rd), 0);
    rdReg(16'h0101, rd); check("R1 cmd", 32'(rd), 0);
    rdReg(16'h0100, rd); check("R1 base", 32'(rd), 32'h1000);
    rdReg(16'h0103, rd); check("R1 status", 32'(rd), 2);
    rdReg(16'h0003, rd); check("R1 vecLo", 32'(rd), 0);
    rdReg(16'h0004, rd); check("R1 vecHi", 32'(rd), 0);

    // R3 arming, readback
    wrReg(16'h0101, 16'hC000);
    rdReg(16'h0101, rd); check("R3 cmd readback", 32'(rd), 32'hC000);

    // R2 R7 R9 R10 sweep over every mode code with junk upper bits
    for (int c = 0; c < 32; c++) begin
      logic [15:0] cv;
      cv = 16'hA5E0 | 16'(c);
      wrReg(16'h000E, cv);
      rdReg(16'h000E, rd); check("R2 ctrl readback", 32'(rd), 32'(cv));
      rdReg(16'h0103, rd); check("R4 status per mode", 32'(rd), (c == 'h17) ? 0 : 2);
      @(negedge clk);
      check("R10 run per mode", 32'(cpuRun), (c == 1) ? 1 : 0);
      if (c != 'h17) begin
        wrReg(16'h0102, 16'h5A5A);
        check("R7 push ignored outside load", 32'(memWrEn), 0);
      end
    end

    // R3 R7 load mode but not armed
    wrReg(16'h000E, 16'h0017);
    wrReg(16'h0101, 16'h8000);
    rdReg(16'h0103, rd); check("R3 unarmed status", 32'(rd), 2);
    wrReg(16'h0102, 16'h1234);
    check("R7 push ignored unarmed", 32'(memWrEn), 0);
    wrReg(16'h0101, 16'hC000);
    rdReg(16'h0103, rd); check("R4 armed ready", 32'(rd), 0);

    // R5 R6 stream image from reset base (ignored pushes must not move it)
    for (int i = 0; i < NWORDS; i++) begin
      wrReg(16'h0102, {img[2*i+1], img[2*i]});
      check("R5 memWrEn", 32'(memWrEn), 1);
      check("R5 address", 32'(memWrAddr), 32'h1000 + i);
      check("R5 data", 32'(memWrData), {16'h0, img[2*i+1], img[2*i]});
      if (i == 0) begin
        rdReg(16'h0103, rd); check("R4 busy after word", 32'(rd), 1);
      end
    end
    @(negedge clk);
    check("R5 enable drops", 32'(memWrEn), 0);
    rdReg(16'h0100, rd); check("R6 base unchanged", 32'(rd), 32'h1000);

    // R6 rebase
    wrReg(16'h0100, 16'h0040);
    rdReg(16'h0100, rd); check("R6 base readback", 32'(rd), 32'h0040);
    for (int i = 0; i < 3; i++) begin
      wrReg(16'h0102, 16'(16'hF000 + i));
      check("R6 rebased address", 32'(memWrAddr), 32'h0040 + i);
    end
    wrReg(16'h0101, 16'hC003);
    rdReg(16'h0103, rd); check("R4 rearm clears", 32'(rd), 0);

    // R8 vector halves
    wrReg(16'h0003, 16'h2000);
    wrReg(16'h0004, 16'h0001);
    rdReg(16'h0003, rd); check("R8 vecLo", 32'(rd), 32'h2000);
    rdReg(16'h0004, rd); check("R8 vecHi", 32'(rd), 32'h0001);

    // R9 release timing and vector
    wrReg(16'h000E, 16'h0001);
    check("R9 not in write cycle", 32'(cpuRun), 0);
    @(negedge clk);
    check("R9 run next cycle", 32'(cpuRun), 1);
    check("R9 vector", cpuResetVec, 32'h0001_2000);
    wrReg(16'h0003, 16'hBEEF);
    check("R9 vector held", cpuResetVec, 32'h0001_2000);
    rdReg(16'h0003, rd); check("R8 vecLo rewrite", 32'(rd), 32'hBEEF);
    wrReg(16'h0102, 16'h7777);
    check("R7 push ignored running", 32'(memWrEn), 0);

    // R10 leave start
    wrReg(16'h000E, 16'h0017);
    check("R10 still run in write cycle", 32'(cpuRun), 1);
    @(negedge clk);
    check("R10 run drops", 32'(cpuRun), 0);

    // R11 reads
    rdReg(16'h0055, rd); check("R11 unmapped", 32'(rd), 0);
    rdReg(16'h0102, rd); check("R11 port reads zero", 32'(rd), 0);
    regAddr = 16'h0100; #1;
    check("R11 no read strobe", 32'(regRdData), 0);

    finishRun();
  end
endmodule